// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Scheduler

This block keeps a fast-page-mode DRAM alive. It runs an interval timer that spaces 2048 refreshes evenly across every 32 ms retention window, so a refresh falls due about every 15.6 us. Each refresh it issues is a CAS-before-RAS cycle, so no row address is driven. It gets the bus through a request/grant handshake with the access sequencer. While its own cycle is in progress, a pin multiplexer passes its strobe values to the DRAM. At all other times the multiplexer passes the sequencer's values through unchanged.

After reset the block keeps host access blocked. It waits a long pause, then issues eight refresh cycles, and only then raises the host-ready flag. When the sequencer does not grant, due refreshes are counted as postponed, up to a parameterised limit. Once the grant returns they run back to back. If one more refresh falls due while the limit is already reached, the retention deadline is treated as missed. The block then drops host-ready and repeats the eight-cycle wake-up burst.

Every time span is a parameter counted in clock cycles. The defaults assume a 100 MHz clock. The RAS precharge length is derived so that both the precharge minimum and the row cycle minimum are met.

Top module: `rfs_refresh_sched`

## Requirements
- R1: While reset is asserted, host_ready and ref_req are 0 and the DRAM pins equal the sequencer pins.
- R2: After reset is released, ref_req stays 0 during the pause. It is first seen high on the PAUSE_CYC-th clock after release.
- R3: After the pause, exactly WAKE_N refresh cycles complete before host_ready rises. host_ready rises on the clock that ends the last of them.
- R4: In every refresh cycle, CAS falls T_SETUP clocks before RAS falls, and WE stays high for the whole cycle.
- R5: RAS stays low for T_RASL clocks. CAS stays low for the first T_CHR of those clocks and then rises while RAS is still low.
- R6: After RAS rises, both strobes stay high for at least T_PRE = max(T_RP, T_RC - T_RASL) clocks. When refreshes run back to back, one further idle clock follows before the next CAS fall.
- R7: With host_ready high and the grant always given, successive refresh cycles start exactly REF_INTERVAL clocks apart.
- R8: While the grant is withheld, ref_req stays high and the due refreshes are counted. When the grant returns, exactly that many cycles run back to back, and ref_req then falls.
- R9: If a refresh falls due while PEND_MAX are already postponed, host_ready falls and WAKE_N refresh cycles are rerun. host_ready then rises again with no refresh left pending.
- R10: While no refresh cycle is in progress, the DRAM RAS, CAS and WE pins follow the sequencer pins.
- R11: A refresh cycle starts only on a clock where ref_req and ref_gnt are both high. A grant given without a request has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Sequencer grants the bus for one refresh cycle |
| seq_ras_n | input | 1 | RAS value from the access sequencer |
| seq_cas_n | input | 1 | CAS value from the access sequencer |
| seq_we_n | input | 1 | WE value from the access sequencer |
| ref_req | output | 1 | A refresh is waiting and the engine is idle |
| host_ready | output | 1 | Wake-up complete; host access allowed |
| dram_ras_n | output | 1 | RAS pin to the DRAM |
| dram_cas_n | output | 1 | CAS pin to the DRAM |
| dram_we_n | output | 1 | WE pin to the DRAM |

## Verification
The refresh engine is driven under three grant patterns.

- With a grant held high throughout, the bench sees the wake-up burst and the steady REF_INTERVAL spacing.
- With the grant withheld across two ticks and then returned, the bench sees whether postponed refreshes are counted exactly and replayed back to back with the minimum gap.
- With the grant withheld past the pending limit, the bench sees whether an overflow is told apart from ordinary postponement and reruns the full burst.

Toggling the sequencer pins, with and without a stray grant, shows that the multiplexer passes them through and that the engine does not start on its own.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    MODE_PAUSE = 2'd0,
    MODE_BURST = 2'd1,
    MODE_RUN   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SETUP = 2'd1,
    ENG_RASL  = 2'd2,
    ENG_PRE   = 2'd3
  } eng_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Precharge length that meets both the precharge minimum and the row cycle minimum.
  function automatic int unsigned pre_len(input int unsigned rp, input int unsigned rc,
                                          input int unsigned rasl);
    return (rc > rasl) ? max_u(rp, rc - rasl) : rp;
  endfunction

  function automatic int unsigned ctr_w(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int unsigned REF_INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = rfs_pkg::ctr_w(REF_INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rfs_pend_counter.sv
module rfs_pend_counter #(
  parameter int unsigned PEND_MAX = 8,
  localparam int unsigned PW = rfs_pkg::ctr_w(PEND_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic          dec,
  output logic [PW-1:0] pend,
  output logic          has_pend,
  output logic          overflow
);
  localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

  assign has_pend = (pend != '0);
  assign overflow = !clear && tick && !dec && (pend == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pend <= '0;
    end else begin
      unique case ({tick, dec})
        2'b10:   if (pend != FULL) pend <= pend + 1'b1;
        2'b01:   if (pend != '0)   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end
endmodule

// File: rtl/rfs_mode_ctrl.sv
module rfs_mode_ctrl #(
  parameter int unsigned PAUSE_CYC = 10000,
  parameter int unsigned WAKE_N    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               overflow,
  input  logic               cyc_done,
  output rfs_pkg::mode_e     mode
);
  import rfs_pkg::*;

  localparam int unsigned PCW = ctr_w(PAUSE_CYC);
  localparam int unsigned BCW = ctr_w(WAKE_N);
  localparam logic [PCW-1:0] P_LAST = PCW'(PAUSE_CYC - 1);
  localparam logic [BCW-1:0] B_LAST = BCW'(WAKE_N - 1);

  logic [PCW-1:0] pause_cnt;
  logic [BCW-1:0] burst_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= MODE_PAUSE;
      pause_cnt <= '0;
      burst_cnt <= '0;
    end else begin
      unique case (mode)
        MODE_PAUSE: begin
          if (pause_cnt == P_LAST) begin
            mode      <= MODE_BURST;
            burst_cnt <= '0;
          end else begin
            pause_cnt <= pause_cnt + 1'b1;
          end
        end
        MODE_BURST: begin
          if (cyc_done) begin
            if (burst_cnt == B_LAST) begin
              mode <= MODE_RUN;
            end else begin
              burst_cnt <= burst_cnt + 1'b1;
            end
          end
        end
        MODE_RUN: begin
          if (overflow) begin
            mode      <= MODE_BURST;
            burst_cnt <= '0;
          end
        end
        default: mode <= MODE_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/rfs_cbr_engine.sv
module rfs_cbr_engine #(
  parameter int unsigned T_SETUP = 1,
  parameter int unsigned T_CHR   = 1,
  parameter int unsigned T_RASL  = 6,
  parameter int unsigned T_PRE   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  import rfs_pkg::*;

  localparam int unsigned LMAX = max_u(max_u(T_SETUP, T_RASL), T_PRE);
  localparam int unsigned CW   = ctr_w(LMAX);

  eng_e          st;
  logic [CW-1:0] cnt;
  logic          last;

  always_comb begin
    unique case (st)
      ENG_SETUP: last = (cnt == CW'(T_SETUP - 1));
      ENG_RASL:  last = (cnt == CW'(T_RASL - 1));
      ENG_PRE:   last = (cnt == CW'(T_PRE - 1));
      default:   last = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ENG_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ENG_IDLE: begin
          cnt <= '0;
          if (start) st <= ENG_SETUP;
        end
        ENG_SETUP: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) st <= ENG_RASL;
        end
        ENG_RASL: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) st <= ENG_PRE;
        end
        ENG_PRE: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) st <= ENG_IDLE;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign busy  = (st != ENG_IDLE);
  assign done  = (st == ENG_PRE) && last;
  assign ras_n = (st != ENG_RASL);
  assign cas_n = !((st == ENG_SETUP) || ((st == ENG_RASL) && (cnt < CW'(T_CHR))));
  assign we_n  = 1'b1;
endmodule

// File: rtl/rfs_refresh_sched.sv
module rfs_refresh_sched #(
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned PAUSE_CYC    = 10000,
  parameter int unsigned WAKE_N       = 8,
  parameter int unsigned PEND_MAX     = 8,
  parameter int unsigned T_SETUP      = 1,
  parameter int unsigned T_CHR        = 1,
  parameter int unsigned T_RASL       = 6,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned T_RC         = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic seq_ras_n,
  input  logic seq_cas_n,
  input  logic seq_we_n,
  output logic ref_req,
  output logic host_ready,
  output logic dram_ras_n,
  output logic dram_cas_n,
  output logic dram_we_n
);
  import rfs_pkg::*;

  localparam int unsigned T_PRE = pre_len(T_RP, T_RC, T_RASL);
  localparam int unsigned PW    = ctr_w(PEND_MAX);
  localparam int unsigned NPIN  = 3;

  mode_e         mode;
  logic          run;
  logic          tick;
  logic          overflow;
  logic [PW-1:0] pend;
  logic          has_pend;
  logic          cyc_start;
  logic          cyc_done;
  logic          eng_busy;
  logic          eng_ras_n, eng_cas_n, eng_we_n;

  assign run        = (mode == MODE_RUN);
  assign host_ready = run;
  assign ref_req    = !eng_busy && ((mode == MODE_BURST) || (run && has_pend));
  assign cyc_start  = ref_req && ref_gnt;

  rfs_interval_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  rfs_pend_counter #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!run),
    .tick    (tick),
    .dec     (cyc_done && run),
    .pend    (pend),
    .has_pend(has_pend),
    .overflow(overflow)
  );

  rfs_mode_ctrl #(.PAUSE_CYC(PAUSE_CYC), .WAKE_N(WAKE_N)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .overflow(overflow),
    .cyc_done(cyc_done),
    .mode    (mode)
  );

  rfs_cbr_engine #(
    .T_SETUP(T_SETUP),
    .T_CHR  (T_CHR),
    .T_RASL (T_RASL),
    .T_PRE  (T_PRE)
  ) u_eng (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cyc_start),
    .busy (eng_busy),
    .done (cyc_done),
    .ras_n(eng_ras_n),
    .cas_n(eng_cas_n),
    .we_n (eng_we_n)
  );

  // Pin multiplexer: the engine owns the strobes only while its cycle runs.
  logic [NPIN-1:0] own_v, seq_v, pin_v;
  assign own_v = {eng_we_n, eng_cas_n, eng_ras_n};
  assign seq_v = {seq_we_n, seq_cas_n, seq_ras_n};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin_mux
    assign pin_v[g] = eng_busy ? own_v[g] : seq_v[g];
  end

  assign dram_ras_n = pin_v[0];
  assign dram_cas_n = pin_v[1];
  assign dram_we_n  = pin_v[2];
endmodule

// File: rtl/rfs_sched_checker.sv
module rfs_sched_checker #(
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned PEND_MAX     = 8,
  parameter int unsigned PW           = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ref_gnt,
  input logic           ref_req,
  input logic           host_ready,
  input logic           dram_ras_n,
  input logic           dram_cas_n,
  input logic           dram_we_n,
  input logic           eng_busy,
  input logic           cyc_done,
  input logic           tick,
  input logic           overflow,
  input rfs_pkg::mode_e mode,
  input logic [PW-1:0]  pend
);
  int  since_tick;
  logic seen_tick;

  always_ff @(posedge clk) begin
    if (!rst_n || !host_ready) begin
      since_tick <= 0;
      seen_tick  <= 1'b0;
    end else if (tick) begin
      since_tick <= 0;
      seen_tick  <= 1'b1;
    end else begin
      since_tick <= since_tick + 1;
    end
  end

  AST_NO_REQ_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == rfs_pkg::MODE_PAUSE) |-> !ref_req && !host_ready); // R2

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> $past(cyc_done)); // R3

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $fell(dram_ras_n)) |-> (!dram_cas_n && $past(!dram_cas_n))); // R4

  AST_WE_HIGH_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> dram_we_n); // R4

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_tick) |-> (since_tick == REF_INTERVAL - 1)); // R7

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req); // R8

  AST_OVERFLOW_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> !host_ready); // R9

  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(ref_req && ref_gnt)); // R11
endmodule

bind rfs_refresh_sched rfs_sched_checker #(
  .REF_INTERVAL(REF_INTERVAL),
  .PEND_MAX    (PEND_MAX),
  .PW          (PW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .host_ready(host_ready),
  .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n),
  .dram_we_n (dram_we_n),
  .eng_busy  (eng_busy),
  .cyc_done  (cyc_done),
  .tick      (tick),
  .overflow  (overflow),
  .mode      (mode),
  .pend      (pend)
);

// File: tb/tb_rfs_refresh_sched.sv
module tb_rfs_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int P_REF   = 50;
  localparam int P_PAUSE = 20;
  localparam int P_WAKE  = 8;
  localparam int P_PEND  = 3;
  localparam int P_SETUP = 1;
  localparam int P_CHR   = 2;
  localparam int P_RASL  = 4;
  localparam int P_RP    = 2;
  localparam int P_RC    = 7;
  localparam int EXP_PRE = (P_RC - P_RASL > P_RP) ? (P_RC - P_RASL) : P_RP;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic seq_ras_n = 1'b1, seq_cas_n = 1'b1, seq_we_n = 1'b1;
  logic ref_req, host_ready, dram_ras_n, dram_cas_n, dram_we_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rfs_refresh_sched #(
    .REF_INTERVAL(P_REF), .PAUSE_CYC(P_PAUSE), .WAKE_N(P_WAKE), .PEND_MAX(P_PEND),
    .T_SETUP(P_SETUP), .T_CHR(P_CHR), .T_RASL(P_RASL), .T_RP(P_RP), .T_RC(P_RC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
    .seq_ras_n(seq_ras_n), .seq_cas_n(seq_cas_n), .seq_we_n(seq_we_n),
    .ref_req(ref_req), .host_ready(host_ready),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
  );

  typedef struct {
    int    setup;
    int    rasl;
    int    chr;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   start_t[$];
  int   n_tests = 0, n_fail = 0;
  int   tcyc = 0, starts = 0, ends = 0, last_gap = 0;
  int   m_phase = 0, m_setup = 0, m_rasl = 0, m_chr = 0, m_we = 0, m_gap = 1000;
  bit   mon_on = 1'b1;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.setup = P_SETUP; e.rasl = P_RASL; e.chr = P_CHR; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_ends(input int target);
    for (int i = 0; i < 2000 && ends < target; i++) @(negedge clk);
  endtask

  // Monitor: rebuilds each refresh cycle from the pins and scores it.
  always @(negedge clk) begin
    tcyc++;
    if (!rst_n || !mon_on) begin
      m_phase = 0;
      m_gap   = 1000;
    end else begin
      case (m_phase)
        0: begin
          if (!dram_cas_n && dram_ras_n) begin
            starts++;
            start_t.push_back(tcyc);
            last_gap = m_gap;
            if (ends > 0) check(m_gap >= EXP_PRE, "R6", "precharge clocks", m_gap, EXP_PRE);
            m_phase = 1; m_setup = 1; m_rasl = 0; m_chr = 0;
            m_we = dram_we_n ? 0 : 1;
          end else begin
            m_gap++;
          end
        end
        1: begin
          if (!dram_we_n) m_we++;
          if (!dram_ras_n) begin
            m_phase = 2; m_rasl = 1; m_chr = dram_cas_n ? 0 : 1;
          end else begin
            m_setup++;
          end
        end
        default: begin
          if (!dram_we_n) m_we++;
          if (dram_ras_n) begin
            ends++;
            m_phase = 0;
            m_gap   = 1;
            if (exp_q.size() == 0) begin
              check(1'b0, "R11", "unexpected refresh cycle", ends, 0);
            end else begin
              exp_t e;
              e = exp_q.pop_front();
              check(m_setup == e.setup, "R4", {e.tag, " CAS-to-RAS setup"}, m_setup, e.setup);
              check(m_we == 0, "R4", {e.tag, " WE low clocks"}, m_we, 0);
              check(m_rasl == e.rasl, "R5", {e.tag, " RAS low clocks"}, m_rasl, e.rasl);
              check(m_chr == e.chr, "R5", {e.tag, " CAS hold clocks"}, m_chr, e.chr);
            end
          end else begin
            m_rasl++;
            if (!dram_cas_n) m_chr++;
          end
        end
      endcase
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
    finish_run();
  end

  initial begin
    int n, t_run, t_drop, s0, e0, ready_seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(host_ready == 1'b0, "R1", "host_ready in reset", host_ready, 0);
    check(ref_req == 1'b0, "R1", "ref_req in reset", ref_req, 0);
    check({dram_ras_n, dram_cas_n, dram_we_n} == 3'b111, "R1", "pins in reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 7);

    // R2 / R3: pause then wake-up burst with grant held
    push_exp(P_WAKE, "wake");
    ref_gnt = 1'b1;
    rst_n   = 1'b1;
    n = 0; ready_seen = 0;
    do begin
      @(negedge clk);
      n++;
      if (host_ready) ready_seen = 1;
    end while (!ref_req && n < 1000);
    check(n == P_PAUSE, "R2", "clocks until first request", n, P_PAUSE);
    check(ready_seen == 0, "R2", "host_ready during pause", ready_seen, 0);
    for (int i = 0; i < 1000 && !host_ready; i++) @(negedge clk);
    check(ends == P_WAKE, "R3", "cycles before ready", ends, P_WAKE);
    check(host_ready == 1'b1, "R3", "host_ready after burst", host_ready, 1);
    ref_gnt = 1'b0;
    t_run = tcyc;

    // R10 / R11: pins follow the sequencer, a stray grant starts nothing
    mon_on = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ref_gnt = (i >= 8);
      {seq_we_n, seq_cas_n, seq_ras_n} = 3'(i);
      #1;
      check({dram_we_n, dram_cas_n, dram_ras_n} == 3'(i), (i >= 8) ? "R11" : "R10",
            "pin pass-through", {dram_we_n, dram_cas_n, dram_ras_n}, i % 8);
    end
    @(negedge clk);
    ref_gnt = 1'b0;
    {seq_we_n, seq_cas_n, seq_ras_n} = 3'b111;
    @(negedge clk);
    mon_on = 1'b1;

    // R8: two ticks postponed, then replayed back to back
    while (tcyc < t_run + 2 * P_REF + 10) @(negedge clk);
    check(ref_req == 1'b1, "R8", "request held without grant", ref_req, 1);
    check(starts == P_WAKE, "R11", "no cycle without grant", starts, P_WAKE);
    s0 = starts; e0 = ends;
    push_exp(2, "postponed");
    ref_gnt = 1'b1;
    wait_ends(e0 + 2);
    check(last_gap == EXP_PRE + 1, "R6", "back-to-back gap", last_gap, EXP_PRE + 1);
    repeat (3) @(negedge clk);
    check(starts == s0 + 2, "R8", "replayed cycle count", starts - s0, 2);
    check(ref_req == 1'b0, "R8", "request after replay", ref_req, 0);

    // R7: steady spacing with the grant held
    push_exp(3, "periodic");
    e0 = ends;
    wait_ends(e0 + 3);
    ref_gnt = 1'b0;
    n = start_t.size();
    check(start_t[n-1] - start_t[n-2] == P_REF, "R7", "refresh spacing",
          start_t[n-1] - start_t[n-2], P_REF);
    check(start_t[n-2] - start_t[n-3] == P_REF, "R7", "refresh spacing",
          start_t[n-2] - start_t[n-3], P_REF);

    // R9: starvation past the pending limit reruns the wake-up burst
    t_drop = tcyc;
    for (int i = 0; i < 10 * P_REF && host_ready; i++) @(negedge clk);
    n = tcyc - t_drop;
    check(host_ready == 1'b0, "R9", "host_ready after overflow", host_ready, 0);
    check(n > P_PEND * P_REF && n <= (P_PEND + 1) * P_REF, "R9", "clocks to overflow",
          n, (P_PEND + 1) * P_REF);
    check(ref_req == 1'b1, "R9", "burst request", ref_req, 1);
    push_exp(P_WAKE, "rewake");
    e0 = ends;
    ref_gnt = 1'b1;
    for (int i = 0; i < 1000 && !host_ready; i++) @(negedge clk);
    check(ends - e0 == P_WAKE, "R9", "rerun burst cycles", ends - e0, P_WAKE);
    s0 = starts;
    repeat (P_REF - 5) @(negedge clk);
    check(starts == s0, "R9", "pending cleared after rerun", starts - s0, 0);
    check(ref_req == 1'b0, "R9", "no request after rerun", ref_req, 0);
    check(exp_q.size() == 0, "R3", "expected cycles left", exp_q.size(), 0);
    finish_run();
  end
endmodule